// File: doc/BRIEF.md
# Half-Warp Banked Scratchpad Arbiter

This block takes one shared-memory request for a whole 32-lane warp and carries it out against a scratchpad made of 16 banks of 32-bit words. Each lane brings its own word address, write enable, write data and an active flag. The block splits the warp into two groups of 16 lanes. It serves the groups in alternate clock cycles against the same banks, so the two groups do not each get half of the storage. In every cycle at most 16 lanes reach the memory.

Within one group, lanes that map to the same bank but ask for different words cannot all be served together. The block replays the group for as many cycles as the worst bank needs. Lanes that ask for the same word are served together. When the warp is finished the block returns one read word per lane, pulses `done`, and reports the total cycle count and the replay count of each group. A pipeline stage issues a request with a one-cycle `start` while the block is idle. It then waits for `done`.

Top module: `smem_arbiter`

## Requirements
- R1: After reset `busy`, `done`, `rd_data` and all three counts are zero, and every scratchpad word reads as zero.
- R2: A `start` seen while idle is taken in that edge and `busy` is high in the following cycle. A `start` seen while busy is ignored: neither its writes nor its addresses affect the storage or the results.
- R3: Word address bits [3:0] select the bank and bits [7:4] the row within it. Any lane of either group may read or write any of the 256 words.
- R4: A group whose active lanes all fall in different banks is served in a single cycle.
- R5: A group needs as many cycles as the largest number of distinct words its active lanes request in any one bank. In each replay cycle, each bank serves the lowest-numbered lane still pending together with every pending lane that asks for that same word.
- R6: Lanes of one group that ask for the same word are served in the same cycle and add no replay cycle.
- R7: Group 0 (lanes 0–15) is served in slots 0, 2, 4, … and group 1 (lanes 16–31) in slots 1, 3, 5, …. If the groups need N0 and N1 cycles, the warp takes max(2·N0−1, 2·N1, 1) cycles. A group's replay count never depends on the other group's pattern.
- R8: Inactive lanes take no part in the access and return zero. A warp with no active lane finishes in one cycle, with both group counts zero.
- R9: When lanes of one group write the same word, the value of the highest-numbered of those lanes remains. A lane that reads a word in the same cycle as it is written gets the earlier value.
- R10: `done` is high for exactly one cycle, T cycles after the edge that accepted `start`, and `busy` is low in that cycle. `rd_data` and the counts keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| req_active | input | 32 | Per-lane participation flag |
| req_we | input | 32 | Per-lane write enable |
| req_addr | input | 256 | Per-lane word address, lane i at bits [8i+7:8i] |
| req_wdata | input | 1024 | Per-lane write data, lane i at bits [32i+31:32i] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1024 | Per-lane read result, lane i at bits [32i+31:32i] |
| total_cycles | output | 6 | Cycles the last warp took |
| half0_cycles | output | 5 | Replay cycles of lanes 0–15 |
| half1_cycles | output | 5 | Replay cycles of lanes 16–31 |

## Verification
The accepting edge starts the count. `busy` is due one cycle later. `done`, the read words and the counts all arrive together T cycles later, where T follows the R7 formula from the per-bank distinct-word counts of each group. The bench drives `start` on a falling edge and counts falling edges after the accepting rising edge until `done` appears. It compares that count with its own T. It samples the outputs there, and again one falling edge later to confirm that the pulse has ended and that the results are held. Expected words come from a shadow copy of the storage that the bench updates by the R9 rules.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int LANES      = 32;
    localparam int HALF_LANES = LANES / 2;
    localparam int NBANKS     = 16;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int BANK_W     = $clog2(NBANKS);
    localparam int ROW_W      = ADDR_W - BANK_W;
    localparam int ROWS       = 1 << ROW_W;
    localparam int TOT_W      = $clog2(2 * HALF_LANES + 1);
    localparam int HCNT_W     = $clog2(HALF_LANES + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ROW_W-1:0]  row_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t wdata;
    } lane_req_t;

    typedef struct packed {
        logic  en;
        logic  we;
        row_t  row;
        word_t wdata;
    } bank_cmd_t;

    function automatic bank_t bank_of(addr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic row_t row_of(addr_t a);
        return a[ADDR_W-1:BANK_W];
    endfunction
endpackage

// File: rtl/smem_pick.sv
module smem_pick
    import smem_pkg::*;
(
    input  lane_req_t [HALF_LANES-1:0] lreq,
    input  logic      [HALF_LANES-1:0] pend,
    output logic      [HALF_LANES-1:0] served,
    output bank_cmd_t [NBANKS-1:0]     cmd
);
    always_comb begin
        cmd    = '0;
        served = '0;
        // lowest pending lane claims each bank and fixes its row
        for (int i = 0; i < HALF_LANES; i++) begin
            if (pend[i] && !cmd[bank_of(lreq[i].addr)].en) begin
                cmd[bank_of(lreq[i].addr)].en  = 1'b1;
                cmd[bank_of(lreq[i].addr)].row = row_of(lreq[i].addr);
            end
        end
        // every pending lane on the claimed word rides along
        for (int j = 0; j < HALF_LANES; j++) begin
            served[j] = pend[j] && cmd[bank_of(lreq[j].addr)].en
                        && (cmd[bank_of(lreq[j].addr)].row == row_of(lreq[j].addr));
        end
        // ascending scan: highest served writer's data is kept
        for (int j = 0; j < HALF_LANES; j++) begin
            if (served[j] && lreq[j].we) begin
                cmd[bank_of(lreq[j].addr)].we    = 1'b1;
                cmd[bank_of(lreq[j].addr)].wdata = lreq[j].wdata;
            end
        end
    end
endmodule

// File: rtl/smem_bank.sv
module smem_bank
    import smem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bank_cmd_t cmd,
    output word_t     rdata
);
    word_t mem [ROWS];

    // read sees the value before this cycle's write
    assign rdata = mem[cmd.row];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (cmd.en && cmd.we) begin
            mem[cmd.row] <= cmd.wdata;
        end
    end
endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
    import smem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cur_any,
    input  logic              rest_empty,
    output logic              busy,
    output logic              load,
    output logic              cur_half,
    output logic              done,
    output logic [TOT_W-1:0]  total_cycles,
    output logic [HCNT_W-1:0] half0_cycles,
    output logic [HCNT_W-1:0] half1_cycles
);
    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy         <= 1'b0;
            cur_half     <= 1'b0;
            done         <= 1'b0;
            total_cycles <= '0;
            half0_cycles <= '0;
            half1_cycles <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy         <= 1'b1;
                cur_half     <= 1'b0;
                total_cycles <= '0;
                half0_cycles <= '0;
                half1_cycles <= '0;
            end else if (busy) begin
                total_cycles <= total_cycles + 1'b1;
                if (cur_any && !cur_half) half0_cycles <= half0_cycles + 1'b1;
                if (cur_any &&  cur_half) half1_cycles <= half1_cycles + 1'b1;
                cur_half <= ~cur_half;
                if (rest_empty) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter
    import smem_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [LANES-1:0]         req_active,
    input  logic [LANES-1:0]         req_we,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*WORD_W-1:0]  req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*WORD_W-1:0]  rd_data,
    output logic [TOT_W-1:0]         total_cycles,
    output logic [HCNT_W-1:0]        half0_cycles,
    output logic [HCNT_W-1:0]        half1_cycles
);
    lane_req_t [LANES-1:0]      in_reqs;
    lane_req_t [LANES-1:0]      reqs;
    lane_req_t [HALF_LANES-1:0] cur_reqs;
    logic [HALF_LANES-1:0]      pend0, pend1, pend_cur, pend_oth, pick_pend, served;
    bank_cmd_t [NBANKS-1:0]     cmd;
    word_t     [NBANKS-1:0]     bank_rdata;
    logic [LANES-1:0][WORD_W-1:0] rd_q;
    logic load, cur_half, cur_any, rest_empty;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            in_reqs[i].we    = req_we[i];
            in_reqs[i].addr  = req_addr[i*ADDR_W +: ADDR_W];
            in_reqs[i].wdata = req_wdata[i*WORD_W +: WORD_W];
        end
    end

    assign cur_reqs   = cur_half ? reqs[LANES-1:HALF_LANES] : reqs[HALF_LANES-1:0];
    assign pend_cur   = cur_half ? pend1 : pend0;
    assign pend_oth   = cur_half ? pend0 : pend1;
    assign pick_pend  = busy ? pend_cur : '0;
    assign cur_any    = |pend_cur;
    assign rest_empty = (pend_oth == '0) && ((pend_cur & ~served) == '0);
    assign rd_data    = rd_q;

    smem_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cur_any(cur_any),
        .rest_empty(rest_empty), .busy(busy), .load(load), .cur_half(cur_half),
        .done(done), .total_cycles(total_cycles),
        .half0_cycles(half0_cycles), .half1_cycles(half1_cycles)
    );

    smem_pick u_pick (
        .lreq(cur_reqs), .pend(pick_pend), .served(served), .cmd(cmd)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        smem_bank u_bank (
            .clk(clk), .rst(rst), .cmd(cmd[b]), .rdata(bank_rdata[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reqs  <= '0;
            pend0 <= '0;
            pend1 <= '0;
            rd_q  <= '0;
        end else if (load) begin
            reqs  <= in_reqs;
            pend0 <= req_active[HALF_LANES-1:0];
            pend1 <= req_active[LANES-1:HALF_LANES];
            rd_q  <= '0;
        end else if (busy) begin
            if (cur_half) pend1 <= pend1 & ~served;
            else          pend0 <= pend0 & ~served;
            for (int j = 0; j < HALF_LANES; j++) begin
                if (served[j])
                    rd_q[j + (cur_half ? HALF_LANES : 0)] <= bank_rdata[bank_of(cur_reqs[j].addr)];
            end
        end
    end
endmodule

// File: rtl/smem_arbiter_chk.sv
module smem_arbiter_chk
    import smem_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [LANES*WORD_W-1:0] rd_data,
    input logic [TOT_W-1:0]        total_cycles,
    input logic [HCNT_W-1:0]       half0_cycles,
    input logic [HCNT_W-1:0]       half1_cycles
);
    logic [TOT_W-1:0] exp_tot;
    logic [TOT_W-1:0] run_len;

    always_comb begin
        int e0, e1, m;
        e0 = (half0_cycles == '0) ? 0 : 2 * int'(half0_cycles) - 1;
        e1 = 2 * int'(half1_cycles);
        m  = (e0 > e1) ? e0 : e1;
        if (m < 1) m = 1;
        exp_tot = TOT_W'(m);
    end

    always_ff @(posedge clk) begin
        if (rst)                run_len <= '0;
        else if (start && !busy) run_len <= '0;
        else if (busy)          run_len <= run_len + 1'b1;
    end

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_results_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rd_data) && $stable(total_cycles)));

    assert_total_formula_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (total_cycles == exp_tot));

    assert_run_length_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == total_cycles));

    assert_half_bound_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((half0_cycles <= HCNT_W'(HALF_LANES)) && (half1_cycles <= HCNT_W'(HALF_LANES))));
endmodule

bind smem_arbiter smem_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_data(rd_data), .total_cycles(total_cycles),
    .half0_cycles(half0_cycles), .half1_cycles(half1_cycles)
);

// File: tb/smem_arbiter_tb.sv
`timescale 1ns/1ps
module smem_arbiter_tb;
    import smem_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LANES-1:0]        req_active = '0, req_we = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES*WORD_W-1:0] req_wdata = '0;
    logic busy, done;
    logic [LANES*WORD_W-1:0] rd_data;
    logic [TOT_W-1:0]  total_cycles;
    logic [HCNT_W-1:0] half0_cycles, half1_cycles;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    logic [LANES-1:0] t_act, t_we;
    logic [7:0]  t_addr [LANES];
    logic [31:0] t_wd   [LANES];
    logic [31:0] shadow [256];

    always #2.5 clk = ~clk;

    smem_arbiter u_dut (
        .clk(clk), .rst(rst), .start(start), .req_active(req_active),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .total_cycles(total_cycles),
        .half0_cycles(half0_cycles), .half1_cycles(half1_cycles)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_req();
        t_act = '0; t_we = '0;
        for (int i = 0; i < LANES; i++) begin t_addr[i] = '0; t_wd[i] = '0; end
    endtask

    function automatic int half_need(int h);
        int cnt [16];
        int mx = 0;
        for (int b = 0; b < 16; b++) cnt[b] = 0;
        for (int i = h*16; i < h*16+16; i++) begin
            bit seen = 0;
            if (!t_act[i]) continue;
            for (int j = h*16; j < i; j++)
                if (t_act[j] && t_addr[j] == t_addr[i]) seen = 1;
            if (!seen) cnt[t_addr[i][3:0]]++;
        end
        for (int b = 0; b < 16; b++) if (cnt[b] > mx) mx = cnt[b];
        return mx;
    endfunction

    // runs the request held in t_*; inject=1 pulses a stray start while busy
    task automatic run_op(string tag, bit inject);
        int n0, n1, t, k;
        logic [31:0] exp_rd [LANES];
        logic [LANES*WORD_W-1:0] snap;
        bit rd_ok;
        n0 = half_need(0);
        n1 = half_need(1);
        t = 1;
        if (n0 > 0 && 2*n0-1 > t) t = 2*n0-1;
        if (2*n1 > t) t = 2*n1;
        for (int i = 0; i < LANES; i++) exp_rd[i] = t_act[i] ? shadow[t_addr[i]] : 32'h0;
        for (int i = 0; i < LANES; i++) if (t_act[i] && t_we[i]) shadow[t_addr[i]] = t_wd[i];

        @(negedge clk);
        req_active = t_act; req_we = t_we;
        for (int i = 0; i < LANES; i++) begin
            req_addr[i*8 +: 8]   = t_addr[i];
            req_wdata[i*32 +: 32] = t_wd[i];
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        chk({tag, " R2"}, "busy after start", 64'(busy), 64'd1);
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
            if (inject && k == 1) begin
                req_active = '1; req_we = '1;
                for (int i = 0; i < LANES; i++) begin
                    req_addr[i*8 +: 8]    = 8'd200;
                    req_wdata[i*32 +: 32] = 32'hDEAD_0000 + 32'(i);
                end
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        chk({tag, " R7"}, "done latency", 64'(k), 64'(t));
        chk({tag, " R7"}, "total_cycles", 64'(total_cycles), 64'(t));
        chk({tag, " R5"}, "half0_cycles", 64'(half0_cycles), 64'(n0));
        chk({tag, " R5"}, "half1_cycles", 64'(half1_cycles), 64'(n1));
        chk({tag, " R10"}, "busy at done", 64'(busy), 64'd0);
        rd_ok = 1;
        for (int i = 0; i < LANES; i++) begin
            if (rd_data[i*32 +: 32] !== exp_rd[i]) begin
                rd_ok = 0;
                chk(tag, $sformatf("rd_data lane %0d", i), 64'(rd_data[i*32 +: 32]), 64'(exp_rd[i]));
            end
        end
        if (rd_ok) n_checks++;
        snap = rd_data;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10"}, "done pulse ended", 64'(done), 64'd0);
        chk({tag, " R10"}, "rd_data held", 64'(rd_data == snap), 64'd1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "total_cycles", 64'(total_cycles), 64'd0);
        chk("R1", "half counts", 64'({half0_cycles, half1_cycles}), 64'd0);
        chk("R1", "rd_data zero", 64'(rd_data == '0), 64'd1);
        clear_req();
        for (int i = 0; i < LANES; i++) begin t_act[i] = 1; t_addr[i] = 8'(i); end
        run_op("R1 R4 zero memory", 0);
    endtask

    task automatic t_spread();
        clear_req();
        for (int i = 0; i < LANES; i++) begin
            t_act[i] = 1; t_we[i] = 1;
            t_addr[i] = 8'((i*17) & 255);
            t_wd[i] = 32'hA500_0000 + 32'(i*3);
        end
        run_op("R3 R4 spread write", 0);
        clear_req();
        for (int i = 0; i < LANES; i++) begin
            t_act[i] = 1;
            t_addr[i] = 8'(((31-i)*17) & 255);
        end
        run_op("R3 cross-lane readback", 0);
    endtask

    task automatic t_conflict();
        clear_req();
        for (int k = 0; k < 4; k++) begin t_act[k] = 1; t_addr[k] = 8'(5 + 16*k); end
        run_op("R5 four-way conflict", 0);
        t_act[16] = 1; t_addr[16] = 8'd9;
        t_act[17] = 1; t_addr[17] = 8'd25;
        run_op("R7 both halves conflict", 0);
        clear_req();
        for (int k = 0; k < 3; k++) begin t_act[16+k] = 1; t_addr[16+k] = 8'(2 + 16*k); end
        run_op("R7 only upper half", 0);
    endtask

    task automatic t_broadcast();
        clear_req();
        for (int i = 0; i < LANES; i++) begin t_act[i] = 1; t_addr[i] = (i < 16) ? 8'd7 : 8'd23; end
        run_op("R6 full broadcast", 0);
        clear_req();
        for (int i = 0; i < 16; i++) begin t_act[i] = 1; t_addr[i] = (i < 8) ? 8'd7 : 8'd23; end
        run_op("R6 two words one bank", 0);
    endtask

    task automatic t_write_race();
        clear_req();
        t_act[14] = 1; t_we[14] = 1; t_addr[14] = 8'd40; t_wd[14] = 32'h0000_1111;
        run_op("R9 seed word", 0);
        clear_req();
        t_act[0] = 1; t_we[0] = 1; t_addr[0] = 8'd40; t_wd[0] = 32'hC0C0_0000;
        t_act[3] = 1; t_we[3] = 1; t_addr[3] = 8'd40; t_wd[3] = 32'hC0C0_0003;
        t_act[9] = 1; t_we[9] = 1; t_addr[9] = 8'd40; t_wd[9] = 32'hC0C0_0009;
        t_act[5] = 1; t_addr[5] = 8'd40;
        t_act[12] = 1; t_addr[12] = 8'd40;
        run_op("R9 same-word writers", 0);
        clear_req();
        t_act[31] = 1; t_addr[31] = 8'd40;
        run_op("R9 winner readback", 0);
    endtask

    task automatic t_inactive();
        clear_req();
        for (int i = 0; i < LANES; i++) t_addr[i] = 8'(i);
        run_op("R8 no active lane", 0);
        clear_req();
        t_act[4] = 1; t_addr[4] = 8'd17;
        t_act[20] = 1; t_addr[20] = 8'd40;
        for (int i = 0; i < LANES; i++) if (!t_act[i]) begin t_we[i] = 1; t_addr[i] = 8'd17; t_wd[i] = 32'hBAD0_0000; end
        run_op("R8 sparse lanes", 0);
        clear_req();
        t_act[0] = 1; t_addr[0] = 8'd17;
        run_op("R8 inactive writes dropped", 0);
    endtask

    task automatic t_busy_start();
        clear_req();
        for (int k = 0; k < 3; k++) begin t_act[k] = 1; t_addr[k] = 8'(6 + 16*k); end
        run_op("R2 start while busy", 1);
        clear_req();
        t_act[8] = 1; t_addr[8] = 8'd200;
        run_op("R2 stray request had no effect", 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) shadow[a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_spread();
        t_conflict();
        t_broadcast();
        t_write_race();
        t_inactive();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule